// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects the interrupt causes of a serial port peripheral into one interrupt line. Five level-type conditions from the FIFOs (receive trigger reached, receive empty, receive full, transmit empty, transmit full) are merged into a sticky status register on every clock. Five single-cycle event pulses (receive overrun, framing error, parity error, receive timeout, modem status change) are latched into the same register. Each cause stays latched until software clears it.

The status register is combined with an enable mask to drive a registered interrupt output. Software sets mask bits through one write address and clears them through another. The mask itself can only be read. Status bits are cleared by writing ones to the status address. A condition that is still active sets its bit again on the next clock after it is cleared. A single registered read port returns the mask or the status.

Top module: `isc_intr_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the mask, the sticky status and `irq` are all cleared to zero.
- R2: A write to address 0 (enable) sets every mask bit written as one and leaves every other mask bit unchanged.
- R3: A write to address 1 (disable) clears every mask bit written as one and leaves every other mask bit unchanged.
- R4: A write to address 2 (the mask address) has no effect on the mask or the status.
- R5: A write to address 3 (status) clears every status bit written as one, unless that bit is set in the same cycle. Status bits written as zero are kept.
- R6: Pulse bit k of `evt_pulse` (k = 0..4: overrun, framing, parity, timeout, modem change) sets status bit 5+k at the next clock edge.
- R7: Each `live_stat` bit k (k = 0..4: rx trigger, rx empty, rx full, tx empty, tx full) that is high is OR-ed into status bit k at every clock edge. A bit that is still active therefore reappears right after it is cleared.
- R8: When a set (event or live) and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when the AND of mask and status was non-zero in the previous cycle. It follows a mask or status change one clock later.
- R10: `rd_data` is registered. At each edge it loads the mask for `rd_addr` = 2, the status for `rd_addr` = 3, and zero for addresses 0 and 1. The mask and status values it loads are those held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_stat | input | 5 | Level conditions from the FIFOs |
| evt_pulse | input | 5 | Single-cycle event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 enable, 1 disable, 2 mask, 3 status) |
| wr_data | input | 10 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 10 | Registered read data |
| irq | output | 1 | Registered interrupt output |

## Verification
The assertions check, on every cycle, the following: that enable and disable writes set or clear exactly the written mask bits, that a write to the mask address leaves the mask unchanged, that every event pulse and every active live bit is present in the status one edge later, that a cleared status bit stays clear when nothing sets it, and that `irq` tracks the previous cycle's masked status. The bench scenarios show the register-level behaviour through the read port. These include a still-active condition reappearing after a clear, a set and a clear colliding on one bit, partial clears that keep the other bits, reads of the write-only addresses returning zero, and the exact clock on which `irq` rises and falls.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int LIVE_W = 5;
  localparam int EVT_W  = 5;
  localparam int STAT_W = LIVE_W + EVT_W;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_SET = 2'd0,
    A_MASK_CLR = 2'd1,
    A_MASK_RO  = 2'd2,
    A_STATUS   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/isc_mask_reg.sv
module isc_mask_reg
  import isc_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      mask_q
);
  logic set_hit, clr_hit;
  assign set_hit = wr_en && (wr_addr == A_MASK_SET);
  assign clr_hit = wr_en && (wr_addr == A_MASK_CLR);

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (set_hit) mask_q <= mask_q | wr_data;
    else if (clr_hit) mask_q <= mask_q & ~wr_data;
  end

  a_r2_enable_sets: assert property (@(posedge clk) disable iff (rst)
    set_hit |=> ((mask_q & $past(wr_data)) == $past(wr_data)));
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> ((mask_q & $past(wr_data)) == '0));
  a_r4_mask_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (!set_hit && !clr_hit) |=> $stable(mask_q));
endmodule

// File: rtl/isc_sticky_stat.sv
module isc_sticky_stat
  import isc_pkg::*;
#(
  parameter int LW = LIVE_W,
  parameter int EW = EVT_W,
  localparam int W = LW + EW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LW-1:0]     live_stat,
  input  logic [EW-1:0]     evt_pulse,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      stat_q
);
  logic [W-1:0] set_vec, clr_vec;

  assign set_vec = {evt_pulse, live_stat};
  assign clr_vec = (wr_en && wr_addr == A_STATUS) ? wr_data : '0;

  // Set has priority over clear on the same bit (R8).
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_vec) | set_vec;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    a_r6_r7_set_captured: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> stat_q[i]);
    a_r5_clear_unset: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !set_vec[i]) |=> !stat_q[i]);
  end
endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mask_q,
  input  logic [W-1:0] stat_q,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(mask_q & stat_q);
  end
endmodule

// File: rtl/isc_intr_ctrl.sv
module isc_intr_ctrl
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LIVE_W-1:0] live_stat,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);
  logic [STAT_W-1:0] mask_q, stat_q;

  isc_mask_reg #(.W(STAT_W)) u_mask (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mask_q(mask_q)
  );

  isc_sticky_stat #(.LW(LIVE_W), .EW(EVT_W)) u_stat (
    .clk(clk), .rst(rst), .live_stat(live_stat), .evt_pulse(evt_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stat_q(stat_q)
  );

  isc_irq_out #(.W(STAT_W)) u_irq (
    .clk(clk), .rst(rst), .mask_q(mask_q), .stat_q(stat_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_MASK_RO: rd_data <= mask_q;
        A_STATUS:  rd_data <= stat_q;
        default:   rd_data <= '0;
      endcase
    end
  end

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    ##1 (irq == $past(|(mask_q & stat_q))));
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (mask_q == '0 && stat_q == '0 && !irq));
endmodule

// File: tb/isc_intr_ctrl_test.sv
module isc_intr_ctrl_test;
  logic       clk = 0;
  logic       rst = 1;
  logic [4:0] live_stat = '0;
  logic [4:0] evt_pulse = '0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [9:0] rd_data;
  logic       irq;

  int n_run = 0, n_fail = 0;
  logic [9:0] m_mod = '0, s_mod = '0;
  logic mon_req = 0;
  bit   done = 0;

  typedef struct { logic [9:0] dat; logic irq_e; string tag; } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  isc_intr_ctrl uut (
    .clk(clk), .rst(rst), .live_stat(live_stat), .evt_pulse(evt_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // Monitor: compare a result with the oldest expected item
  always @(posedge clk) begin
    if (mon_req) begin
      item_t it;
      #2;
      it = exp_q.pop_front();
      n_run++;
      if (rd_data !== it.dat || irq !== it.irq_e) begin
        n_fail++;
        $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                 it.tag, rd_data, irq, it.dat, it.irq_e);
      end
    end
  end

  task automatic chk(input logic act, input logic e, input string tag);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, e);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      2'd0: m_mod = m_mod | d;
      2'd1: m_mod = m_mod & ~d;
      2'd3: s_mod = s_mod & ~d;
      default: ;
    endcase
    s_mod = s_mod | {5'b0, live_stat};
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
    s_mod = s_mod | {e, live_stat};
  endtask

  task automatic do_read(input logic [1:0] a, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = a;
    it.dat = (a == 2'd2) ? m_mod : (a == 2'd3) ? s_mod : '0;
    it.irq_e = |(m_mod & s_mod);
    it.tag = tag;
    exp_q.push_back(it);
    mon_req = 1;
    @(negedge clk);
    mon_req = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    do_read(2'd2, "R1 mask after reset");
    do_read(2'd3, "R1 status after reset");

    do_write(2'd0, 10'h0A5);
    do_read(2'd2, "R2 enable sets bits");
    do_write(2'd0, 10'h300);
    do_read(2'd2, "R2 enable keeps other bits");
    do_write(2'd1, 10'h005);
    do_read(2'd2, "R3 disable clears bits");
    do_write(2'd2, 10'h3FF);
    do_read(2'd2, "R4 mask write ignored");
    do_read(2'd3, "R4 status unchanged by mask write");
    do_read(2'd0, "R10 enable address reads zero");
    do_read(2'd1, "R10 disable address reads zero");

    pulse(5'b00100);
    do_read(2'd3, "R6 parity event latched, R9 irq high");
    do_write(2'd3, 10'h080);
    do_read(2'd3, "R5 status clear, R9 irq low");
    pulse(5'b10001);
    do_read(2'd3, "R6 overrun and modem events");
    do_write(2'd3, 10'h020);
    do_read(2'd3, "R5 partial clear keeps others");

    @(negedge clk); live_stat = 5'b01000;
    s_mod = s_mod | 10'h008;
    do_read(2'd3, "R7 live bit merged");
    do_write(2'd3, 10'h008);
    do_read(2'd3, "R7 active bit reasserts after clear");
    @(negedge clk); live_stat = '0;
    do_write(2'd3, 10'h008);
    do_read(2'd3, "R7 inactive bit stays cleared");

    // Set and clear on the same bit in one cycle
    @(negedge clk);
    evt_pulse = 5'b00010; wr_en = 1; wr_addr = 2'd3; wr_data = 10'h040;
    @(negedge clk);
    evt_pulse = '0; wr_en = 0;
    s_mod = s_mod | 10'h040;
    do_read(2'd3, "R8 set wins over clear");

    do_write(2'd3, 10'h3FF);
    do_read(2'd3, "R5 clear all, R9 irq low");

    // irq timing: state changes at edge P0, irq follows at P1
    do_write(2'd0, 10'h001);
    @(negedge clk); live_stat = 5'b00001;
    @(posedge clk); #2;
    chk(irq, 1'b0, "R9 irq not yet high at status edge");
    @(posedge clk); #2;
    chk(irq, 1'b1, "R9 irq high one clock later");
    s_mod = s_mod | 10'h001;
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd1; wr_data = 10'h001;
    @(posedge clk); #2;
    wr_en = 0;
    chk(irq, 1'b1, "R9 irq still high at mask edge");
    @(posedge clk); #2;
    chk(irq, 1'b0, "R9 irq low one clock after mask clear");
    m_mod = m_mod & ~10'h001;
    do_read(2'd2, "R3 mask after disable");

    // Reset mid-run
    @(negedge clk); live_stat = '0; rst = 1;
    @(negedge clk); rst = 0;
    m_mod = '0; s_mod = '0;
    do_read(2'd2, "R1 mask cleared by reset");
    do_read(2'd3, "R1 status cleared by reset");

    repeat (3) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule